// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Guard Bits

This block multiplies two signed 16-bit fixed-point operands and combines the 32-bit product with a 40-bit accumulator in a single clock cycle. On any cycle the operation select can load the accumulator with the product, add the product to it, subtract the product from it, clear it, or leave it as it is. The new accumulator value is on the output after the clock edge that performed the operation, so the next operation can build on it straight away.

The accumulator has eight guard bits above the 32-bit product range, so long runs of sums can go past 32 bits without losing the true total. A sticky overflow flag records that a result has left the 32-bit signed range. A 16-bit readout gives the upper product word rounded to nearest, and saturates when the accumulator value does not fit in 32 bits.

Top module: `mac40_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the accumulator to zero and clears the overflow flag.
- R2: With `inValid` high and `opSel` = 1 (load), the accumulator takes the two's-complement product of `opA` and `opB`, sign-extended to 40 bits. The previous accumulator value is discarded.
- R3: With `inValid` high and `opSel` = 2 (add), the accumulator becomes its previous value plus the sign-extended product. The result appears on `accOut` one clock edge later and is the base for the next operation.
- R4: With `inValid` high and `opSel` = 3 (subtract), the accumulator becomes its previous value minus the sign-extended product in one cycle.
- R5: With `inValid` high and `opSel` = 4 (clear), the accumulator goes to zero and the overflow flag is cleared.
- R6: When `inValid` is low, or `opSel` is 0, 5, 6 or 7, the accumulator and the overflow flag stay unchanged whatever is on the operand inputs.
- R7: `ovfFlag` goes high on the edge that stores a 40-bit result whose bits 39..31 are not all equal. It stays high through hold, load, add and subtract operations until a clear or a reset.
- R8: When accumulator bits 39..31 are all equal, `rdOut` is bits 31..16 of the low 32 bits plus 0x8000, taken as a signed value (ties round upward). If that addition carries past the largest positive 32-bit value, `rdOut` is 0x7FFF.
- R9: When accumulator bits 39..31 are not all equal, `rdOut` is 0x7FFF if bit 39 is 0 and 0x8000 if bit 39 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation strobe; when low the cycle is a hold |
| opSel | input | 3 | Operation: 0 hold, 1 load, 2 add, 3 subtract, 4 clear, 5..7 hold |
| opA | input | 16 | First signed operand |
| opB | input | 16 | Second signed operand |
| accOut | output | 40 | Current accumulator value |
| ovfFlag | output | 1 | Sticky flag: a result left the 32-bit signed range |
| rdOut | output | 16 | Rounded, saturated upper word of the accumulator |

## Verification
The accumulator is the only arithmetic state and it is on the ports. A wrong sum, a wrong sign extension or a lost guard bit therefore shows on `accOut` on the edge right after the operation, and it carries into every later result. A wrong overflow register shows on `ovfFlag` in the same cycle, either as a missed set at the 32-bit boundary or as a flag that drops without a clear. Mistakes in rounding or saturation in the combinational readout show on `rdOut` as soon as the accumulator lands on a tie, a carry into the sign bit, or a value beyond 32 bits. The tests put the accumulator on each of these points.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

  localparam int OPSEL_W = 3;

  typedef enum logic [OPSEL_W-1:0] {
    OP_HOLD = 3'd0,
    OP_MUL  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_CLR  = 3'd4
  } macOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // write a new accumulator value
    logic useAcc;  // accumulate on top of the current value
    logic negate;  // subtract the product instead of adding it
    logic clear;   // zero accumulator and flag
  } macStrobe_t;

endpackage

// File: rtl/mac40_ctrl.sv
module mac40_ctrl
  import mac40_pkg::*;
(
  input  logic               inValid,
  input  logic [OPSEL_W-1:0] opSel,
  output macStrobe_t         strobe
);

  macOp_e op;

  always_comb begin
    op = macOp_e'(opSel);
    strobe = '0;
    if (inValid) begin
      case (op)
        OP_MUL: strobe.load = 1'b1;
        OP_ADD: begin
          strobe.load   = 1'b1;
          strobe.useAcc = 1'b1;
        end
        OP_SUB: begin
          strobe.load   = 1'b1;
          strobe.useAcc = 1'b1;
          strobe.negate = 1'b1;
        end
        OP_CLR:  strobe.clear = 1'b1;
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/mac40_round.sv
module mac40_round #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] acc,
  output logic [OP_W-1:0]  rd
);

  localparam int PROD_W = 2 * OP_W;
  localparam int TOP_W  = ACC_W - PROD_W + 1;
  localparam int HALF_B = PROD_W - OP_W - 1;

  localparam logic [OP_W-1:0] MAX_POS = {1'b0, {(OP_W-1){1'b1}}};
  localparam logic [OP_W-1:0] MAX_NEG = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [PROD_W:0] HALF    = (PROD_W+1)'(1) << HALF_B;

  logic [TOP_W-1:0]  topBits;
  logic              inRange;
  logic [PROD_W:0]   rounded;

  always_comb begin
    topBits = acc[ACC_W-1:PROD_W-1];
    inRange = (&topBits) | ~(|topBits);
    rounded = {acc[PROD_W-1], acc[PROD_W-1:0]} + HALF;
    if (!inRange) begin
      rd = acc[ACC_W-1] ? MAX_NEG : MAX_POS;
    end else if (rounded[PROD_W] != rounded[PROD_W-1]) begin
      rd = MAX_POS;  // rounding carried into the sign
    end else begin
      rd = rounded[PROD_W-1:PROD_W-OP_W];
    end
  end

endmodule

// File: rtl/mac40_dp.sv
module mac40_dp
  import mac40_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  macStrobe_t       strobe,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic [ACC_W-1:0] acc,
  output logic             ovf
);

  localparam int PROD_W  = 2 * OP_W;
  localparam int GUARD_W = ACC_W - PROD_W;
  localparam int TOP_W   = GUARD_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prodExt;
  logic [ACC_W-1:0]         addend;
  logic [ACC_W-1:0]         base;
  logic [ACC_W-1:0]         nxt;
  logic [TOP_W-1:0]         nxtTop;
  logic                     nxtFits;

  always_comb begin
    prod    = $signed(opA) * $signed(opB);
    prodExt = {{GUARD_W{prod[PROD_W-1]}}, prod};
    addend  = strobe.negate ? (~prodExt + 1'b1) : prodExt;
    base    = strobe.useAcc ? acc : '0;
    nxt     = base + addend;
    nxtTop  = nxt[ACC_W-1:PROD_W-1];
    nxtFits = (&nxtTop) | ~(|nxtTop);
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (strobe.load) begin
      acc <= nxt;
      if (!nxtFits) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [OPSEL_W-1:0] opSel,
  input  logic [OP_W-1:0]    opA,
  input  logic [OP_W-1:0]    opB,
  output logic [ACC_W-1:0]   accOut,
  output logic               ovfFlag,
  output logic [OP_W-1:0]    rdOut
);

  macStrobe_t strobe;

  mac40_ctrl u_ctrl (
    .inValid (inValid),
    .opSel   (opSel),
    .strobe  (strobe)
  );

  mac40_dp #(.OP_W(OP_W), .ACC_W(ACC_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .acc    (accOut),
    .ovf    (ovfFlag)
  );

  mac40_round #(.OP_W(OP_W), .ACC_W(ACC_W)) u_round (
    .acc (accOut),
    .rd  (rdOut)
  );

endmodule

// File: rtl/mac40_chk.sv
module mac40_chk
  import mac40_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [OPSEL_W-1:0] opSel,
  input logic [OP_W-1:0]    opA,
  input logic [OP_W-1:0]    opB,
  input logic [ACC_W-1:0]   accOut,
  input logic               ovfFlag,
  input logic [OP_W-1:0]    rdOut
);

  localparam int PROD_W = 2 * OP_W;

  function automatic logic [ACC_W-1:0] extProd(logic [OP_W-1:0] a, logic [OP_W-1:0] b);
    logic signed [PROD_W-1:0] p;
    p = $signed(a) * $signed(b);
    return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction

  function automatic logic fits32(logic [ACC_W-1:0] v);
    return (&v[ACC_W-1:PROD_W-1]) | ~(|v[ACC_W-1:PROD_W-1]);
  endfunction

  logic isHold;
  assign isHold = !inValid || !(opSel inside {OP_MUL, OP_ADD, OP_SUB, OP_CLR});

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (accOut == '0 && !ovfFlag));

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel == OP_MUL) |=> accOut == extProd($past(opA), $past(opB)));

  p_add_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel == OP_ADD) |=>
      accOut == $past(accOut) + extProd($past(opA), $past(opB)));

  p_sub_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel == OP_SUB) |=>
      accOut == $past(accOut) - extProd($past(opA), $past(opB)));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel == OP_CLR) |=> (accOut == '0 && !ovfFlag));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    isHold |=> ($stable(accOut) && $stable(ovfFlag)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovfFlag && !(inValid && opSel == OP_CLR)) |=> ovfFlag);

  p_flag_r7: assert property (@(posedge clk) disable iff (rst)
    !fits32(accOut) |-> ovfFlag);

  p_sat_r9: assert property (@(posedge clk) disable iff (rst)
    !fits32(accOut) |->
      rdOut == (accOut[ACC_W-1] ? {1'b1, {(OP_W-1){1'b0}}} : {1'b0, {(OP_W-1){1'b1}}}));

endmodule

bind mac40_unit mac40_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .opSel   (opSel),
  .opA     (opA),
  .opB     (opB),
  .accOut  (accOut),
  .ovfFlag (ovfFlag),
  .rdOut   (rdOut)
);

// File: tb/sim_mac40_unit.sv
`timescale 1ns/1ps
module sim_mac40_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [39:0] accOut;
  logic        ovfFlag;
  logic [15:0] rdOut;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mac40_unit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .accOut(accOut), .ovfFlag(ovfFlag), .rdOut(rdOut)
  );

  // called at a falling edge; applies inputs for one rising edge and returns at the next falling edge
  task automatic step(input logic v, input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    inValid = v; opSel = op; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0; opSel = 3'd0;
  endtask

  task automatic chk(input string tag, input logic [39:0] eAcc, input logic eOvf, input logic [15:0] eRd);
    testCnt++;
    if (accOut !== eAcc || ovfFlag !== eOvf || rdOut !== eRd) begin
      failCnt++;
      $display("FAIL %s: acc=%h ovf=%b rd=%h expected acc=%h ovf=%b rd=%h",
               tag, accOut, ovfFlag, rdOut, eAcc, eOvf, eRd);
    end
  endtask

  task automatic tReset();
    chk("R1 reset state", 40'h0, 1'b0, 16'h0000);
  endtask

  task automatic tLoad();
    step(1, 3'd1, 16'd3, 16'hFFFB);
    chk("R2 load 3*-5", 40'hFF_FFFF_FFF1, 1'b0, 16'h0000);
    step(1, 3'd1, 16'd100, 16'd200);
    chk("R2 load discards old", 40'h00_0000_4E20, 1'b0, 16'h0000);
  endtask

  task automatic tAddSub();
    step(1, 3'd1, 16'h4000, 16'h4000);
    chk("R2 load 0x4000^2", 40'h00_1000_0000, 1'b0, 16'h1000);
    step(1, 3'd2, 16'h0100, 16'h0100);
    chk("R3 add back-to-back", 40'h00_1001_0000, 1'b0, 16'h1001);
    step(1, 3'd4 - 3'd1, 16'h2000, 16'h2000);
    chk("R4 subtract", 40'h00_0C01_0000, 1'b0, 16'h0C01);
  endtask

  task automatic tRound();
    step(1, 3'd1, 16'd2, 16'h4000);
    chk("R8 tie rounds up", 40'h00_0000_8000, 1'b0, 16'h0001);
    step(1, 3'd1, 16'd1, 16'h7FFF);
    chk("R8 below half", 40'h00_0000_7FFF, 1'b0, 16'h0000);
    step(1, 3'd1, 16'd3, 16'h8000);
    chk("R8 negative tie", 40'hFF_FFFE_8000, 1'b0, 16'hFFFF);
    step(1, 3'd1, 16'h8000, 16'h8000);
    step(1, 3'd2, 16'h8001, 16'h8000);
    chk("R8 rounding carry saturates", 40'h00_7FFF_8000, 1'b0, 16'h7FFF);
  endtask

  task automatic tOverflow();
    step(1, 3'd2, 16'h8000, 16'h8000);
    chk("R7 R9 positive overflow", 40'h00_BFFF_8000, 1'b1, 16'h7FFF);
    step(1, 3'd3, 16'h8000, 16'h8000);
    step(1, 3'd3, 16'h8000, 16'h8000);
    chk("R7 sticky after return", 40'h00_3FFF_8000, 1'b1, 16'h4000);
    step(1, 3'd4, 16'h1234, 16'h5678);
    chk("R5 clear", 40'h0, 1'b0, 16'h0000);
    step(1, 3'd1, 16'h8000, 16'h7FFF);
    chk("R2 negative product", 40'hFF_C000_8000, 1'b0, 16'hC001);
    step(1, 3'd3, 16'h8000, 16'h8000);
    chk("R4 R8 edge of range", 40'hFF_8000_8000, 1'b0, 16'h8001);
    step(1, 3'd3, 16'h8000, 16'h8000);
    chk("R7 R9 negative overflow", 40'hFF_4000_8000, 1'b1, 16'h8000);
    step(1, 3'd1, 16'd2, 16'd3);
    chk("R7 flag survives load", 40'h00_0000_0006, 1'b1, 16'h0000);
  endtask

  task automatic tHold();
    step(1, 3'd0, 16'h7FFF, 16'h7FFF);
    chk("R6 op 0 holds", 40'h6, 1'b1, 16'h0000);
    step(0, 3'd4, 16'h1111, 16'h2222);
    chk("R6 invalid clear ignored", 40'h6, 1'b1, 16'h0000);
    step(0, 3'd1, 16'h8000, 16'h8000);
    chk("R6 invalid load ignored", 40'h6, 1'b1, 16'h0000);
    for (int k = 5; k < 8; k++) begin
      step(1, 3'(k), 16'h4321, 16'h8765);
      chk("R6 unused op holds", 40'h6, 1'b1, 16'h0000);
    end
  endtask

  task automatic tMidReset();
    step(1, 3'd1, 16'h8000, 16'h8000);
    step(1, 3'd2, 16'h8000, 16'h8000);
    step(1, 3'd2, 16'h8000, 16'h8000);
    chk("R7 overflow before reset", 40'h00_C000_0000, 1'b1, 16'h7FFF);
    rst = 1'b1;
    step(1, 3'd2, 16'h7FFF, 16'h7FFF);
    rst = 1'b0;
    chk("R1 reset mid-run", 40'h0, 1'b0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tReset();
    tLoad();
    tAddSub();
    tRound();
    tOverflow();
    tHold();
    tMidReset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule